// File: doc/BRIEF.md
# Li-ion Charge Control Sequencer

This block is the digital controller of a single-cell linear battery charger. Analog comparators outside the block report whether the battery sits below the conditioning threshold or below the top-up threshold, whether the taper current has reached its end point, whether the supply has dropped into the sleep range, whether the supply is in undervoltage, and whether the pack temperature is out of its window. The controller filters these flags against a prescaled time tick. It then steps through conditioning, fast charge, done, top-up restart, temperature pause, timeout fault with recovery, standby and sleep.

Its outputs switch the conditioning current source, the fast-charge regulator and a small fault-probe current. Two status lines (1 means the open-drain device is on) and an active-low power-good line report the charge state. All timer and filter lengths are parameters counted in ticks. A charge-enable input and a fast-charge timer-enable input, both active low, let the system hold off charging or drop the fast-charge time limit.

Top module: `chg_seq`

## Requirements
- R1: After rst_n low, and on every cycle in which uvlo is high (a synchronous reset), the block is in standby: pre_en, fast_en, flt_cur_en, stat1, stat2 and pgood_n are all 0.
- R2: With charging enabled and batt_low high, the block conditions the cell: pre_en=1, stat1=1, stat2=1. If it is still conditioning after PRE_TICKS ticks, it enters fault, where pre_en, fast_en, stat1 and stat2 are all 0.
- R3: With batt_low low, the block fast-charges: fast_en=1, stat1=1, stat2=0. Entering fast charge clears the timer, and FAST_TICKS counted ticks without termination lead to fault.
- R4: term_det, batt_below_rch (in both directions), batt_low during fast charge, sleep_det and temp_bad take effect only after they have differed from their filtered value for DG_TICKS ticks. A shorter pulse leaves the outputs unchanged.
- R5: A filtered term_det during fast charge gives done (all outputs 0 except stat2=1). A filtered batt_below_rch in done starts a new cycle with a cleared timer.
- R6: A filtered temp_bad pauses charging (all outputs 0) with the timer count held. When temp_bad clears, charging resumes in the same phase with the remaining count.
- R7: In fault with batt_below_rch filtered high, flt_cur_en=1. Once the filtered flag goes low, flt_cur_en=0. When it is next filtered high, the fault clears and a new cycle starts. A fault entered with the flag low keeps flt_cur_en=0 and restarts the same way.
- R8: chg_en_n high stops all charging (standby). Its return to low starts a new cycle with cleared timers, which also clears any fault.
- R9: With tmr_en_n high, the fast-charge timer neither counts nor expires. Any change of tmr_en_n while in fault clears the fault and starts a new cycle. A change outside fault has no effect on the outputs.
- R10: A filtered sleep_det turns all charging off with stat1=stat2=0 and pgood_n=1. When sleep_det clears, a new cycle starts.
- R11: The move from conditioning to fast charge follows batt_low low without filtering. The move back from fast charge to conditioning needs the filtered batt_low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle prescaled time tick |
| batt_low | input | 1 | Battery below the conditioning threshold |
| batt_below_rch | input | 1 | Battery below the top-up threshold |
| term_det | input | 1 | Charge current at the termination level |
| sleep_det | input | 1 | Supply within the sleep range of the battery |
| uvlo | input | 1 | Supply undervoltage, acts as synchronous reset |
| temp_bad | input | 1 | Pack temperature out of window |
| chg_en_n | input | 1 | Charge enable, active low |
| tmr_en_n | input | 1 | Fast-charge timer enable, active low |
| pre_en | output | 1 | Conditioning current on |
| fast_en | output | 1 | Fast-charge regulation on |
| flt_cur_en | output | 1 | Fault-probe current on |
| stat1 | output | 1 | Status line 1 (1 = pulled) |
| stat2 | output | 1 | Status line 2 (1 = pulled) |
| pgood_n | output | 1 | Power good, 0 while input is valid |

## Verification
The bench runs one scripted cell history with short parameters (DG_TICKS=3, PRE_TICKS=8, FAST_TICKS=30). The termination flag is pulsed for every length from one tick up to the filter length, which separates an ignored glitch from a real event at the exact tick. Timeouts are probed one tick before and at the limit, which separates an off-by-one count from the correct one. A temperature pause placed mid-count shows whether the count was held or cleared. Both fault recovery paths, the charge-enable and timer-enable release paths, sleep and undervoltage are each driven from an active charge phase, and the full output vector is compared against the expected encoding.

// File: rtl/chg_pkg.sv
// Shared types for the charge sequencer.
package chg_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_PRE   = 3'd1,
        ST_FAST  = 3'd2,
        ST_DONE  = 3'd3,
        ST_SUSP  = 3'd4,
        ST_FAULT = 3'd5,
        ST_SLEEP = 3'd6
    } chg_state_t;

    // Phase a fresh charge cycle begins in, given the raw low-battery flag
    function automatic chg_state_t start_phase(input logic low);
        return low ? ST_PRE : ST_FAST;
    endfunction

endpackage

// File: rtl/chg_deglitch.sv
// Tick-based input filter.
// The output takes a new value once the raw input has differed from it for
// DG_TICKS consecutive ticks. With RISE_ONLY set, a falling raw input is
// passed at once, so only assertion is filtered.
// Assumes tick is a single-cycle pulse and DG_TICKS >= 1.
module chg_deglitch #(
    parameter int DG_TICKS  = 3,
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic clk,
    input  logic srst_n,
    input  logic tick,
    input  logic raw,
    output logic filt
);
    localparam int CW = (DG_TICKS < 2) ? 1 : $clog2(DG_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DG_TICKS - 1);

    logic [CW-1:0] cnt;

    // Count ticks of disagreement and flip the output when the count completes
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (RISE_ONLY && !raw) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (tick) begin
            if (cnt == LAST) begin
                filt <= raw;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // Without a tick the filtered value only moves on an immediate fall
    AST_DG_NO_EARLY_FLIP: assert property (@(posedge clk) disable iff (!srst_n)
        (!tick && (raw || !RISE_ONLY)) |=> $stable(filt)); // R4

endmodule

// File: rtl/chg_timer.sv
// Safety timer shared by conditioning and fast charge.
// Counts ticks while run is high and saturates at the limit of the selected
// phase; clr restarts it from zero. Holding run low freezes the count.
module chg_timer #(
    parameter int PRE_TICKS  = 14400,
    parameter int FAST_TICKS = 201600
) (
    input  logic clk,
    input  logic srst_n,
    input  logic tick,
    input  logic clr,
    input  logic run,
    input  logic sel_fast,
    output logic expired
);
    localparam int MAXT = (PRE_TICKS > FAST_TICKS) ? PRE_TICKS : FAST_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] PRE_LIM  = CW'(PRE_TICKS);
    localparam logic [CW-1:0] FAST_LIM = CW'(FAST_TICKS);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Limit of the phase currently timed
    always_comb lim = sel_fast ? FAST_LIM : PRE_LIM;

    // Tick counter with clear priority and saturation
    always_ff @(posedge clk) begin
        if (!srst_n || clr) begin
            cnt <= '0;
        end else if (run && tick && (cnt < lim)) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Expiry flag
    always_comb expired = (cnt >= lim);

    // A paused timer keeps its count
    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
        (!run && !clr) |=> $stable(cnt)); // R6

endmodule

// File: rtl/chg_seq.sv
// Charge control sequencer, top level.
// Filters the comparator flags, runs the phase state machine and drives the
// charge enables and status lines. uvlo is folded into the synchronous reset.
// Assumes all flags are already synchronous to clk.
module chg_seq
    import chg_pkg::*;
#(
    parameter int DG_TICKS   = 3,
    parameter int PRE_TICKS  = 14400,
    parameter int FAST_TICKS = 201600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic batt_low,
    input  logic batt_below_rch,
    input  logic term_det,
    input  logic sleep_det,
    input  logic uvlo,
    input  logic temp_bad,
    input  logic chg_en_n,
    input  logic tmr_en_n,
    output logic pre_en,
    output logic fast_en,
    output logic flt_cur_en,
    output logic stat1,
    output logic stat2,
    output logic pgood_n
);
    // Filter lanes: 0 term, 1 top-up (both edges), 2 low, 3 sleep, 4 temp
    localparam int NF = 5;
    localparam logic [NF-1:0] RISE_MASK = 5'b11101;

    logic            srst_n;
    logic [NF-1:0]   raw_v;
    logic [NF-1:0]   filt_v;
    logic            term_f, rch_f, low_f, sleep_f, temp_f;
    chg_state_t      state, nxt;
    logic            ret_fast, seen_above, te_q, te_toggle;
    logic            tmr_clr, tmr_run, tmr_sel_fast, tmr_exp;

    // Combined synchronous reset
    always_comb srst_n = rst_n & ~uvlo;

    // Gather raw flags into filter lanes
    always_comb raw_v = {temp_bad, sleep_det, batt_low, batt_below_rch, term_det};

    // One filter per comparator flag
    for (genvar i = 0; i < NF; i++) begin : g_dg
        chg_deglitch #(
            .DG_TICKS  (DG_TICKS),
            .RISE_ONLY (RISE_MASK[i])
        ) u_dg (
            .clk    (clk),
            .srst_n (srst_n),
            .tick   (tick),
            .raw    (raw_v[i]),
            .filt   (filt_v[i])
        );
    end

    // Name the filtered lanes
    always_comb {temp_f, sleep_f, low_f, rch_f, term_f} = filt_v;

    // Timer enable edge detect
    always_comb te_toggle = (tmr_en_n != te_q);

    // Next-state selection with sleep, enable and temperature priority
    always_comb begin
        nxt = state;
        if (sleep_f) begin
            nxt = ST_SLEEP;
        end else if (chg_en_n) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF, ST_SLEEP: nxt = start_phase(batt_low);
                ST_PRE: begin
                    if (temp_f)        nxt = ST_SUSP;
                    else if (tmr_exp)  nxt = ST_FAULT;
                    else if (!batt_low) nxt = ST_FAST;
                end
                ST_FAST: begin
                    if (temp_f)                    nxt = ST_SUSP;
                    else if (tmr_exp && !tmr_en_n) nxt = ST_FAULT;
                    else if (term_f)               nxt = ST_DONE;
                    else if (low_f)                nxt = ST_PRE;
                end
                ST_DONE:  if (rch_f) nxt = start_phase(batt_low);
                ST_SUSP:  if (!temp_f) nxt = ret_fast ? ST_FAST : ST_PRE;
                ST_FAULT: if (te_toggle || (rch_f && seen_above)) nxt = start_phase(batt_low);
                default:  nxt = ST_OFF;
            endcase
        end
    end

    // Timer control: clear on fresh phase entry, never on resume from pause
    always_comb begin
        tmr_clr      = ((nxt == ST_PRE) || (nxt == ST_FAST)) && (nxt != state) && (state != ST_SUSP);
        tmr_run      = (state == ST_PRE) || ((state == ST_FAST) && !tmr_en_n);
        tmr_sel_fast = (state == ST_FAST) || ((state == ST_SUSP) && ret_fast);
    end

    chg_timer #(
        .PRE_TICKS  (PRE_TICKS),
        .FAST_TICKS (FAST_TICKS)
    ) u_tmr (
        .clk      (clk),
        .srst_n   (srst_n),
        .tick     (tick),
        .clr      (tmr_clr),
        .run      (tmr_run),
        .sel_fast (tmr_sel_fast),
        .expired  (tmr_exp)
    );

    // State, pause return phase, fault recovery flag and timer-enable history
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            state      <= ST_OFF;
            ret_fast   <= 1'b0;
            seen_above <= 1'b0;
            te_q       <= tmr_en_n;
        end else begin
            state <= nxt;
            te_q  <= tmr_en_n;
            if (nxt == ST_SUSP && state != ST_SUSP) ret_fast <= (state == ST_FAST);
            if (nxt == ST_FAULT && state != ST_FAULT) seen_above <= !rch_f;
            else if (state == ST_FAULT && !rch_f)     seen_above <= 1'b1;
        end
    end

    // Output decode
    always_comb begin
        pre_en     = (state == ST_PRE);
        fast_en    = (state == ST_FAST);
        flt_cur_en = (state == ST_FAULT) && rch_f && !seen_above;
        stat1      = (state == ST_PRE) || (state == ST_FAST);
        stat2      = (state == ST_PRE) || (state == ST_DONE);
        pgood_n    = (state == ST_SLEEP);
    end

    // Disabled charge never drives a charge path in the next cycle
    AST_CE_NO_CHARGE: assert property (@(posedge clk) disable iff (!srst_n)
        chg_en_n |=> (!pre_en && !fast_en)); // R8

    // A filtered sleep flag releases power good next cycle
    AST_SLEEP_PG_OFF: assert property (@(posedge clk) disable iff (!srst_n)
        sleep_f |=> pgood_n); // R10

    // Conditioning timeout leads to fault
    AST_PRE_TIMEOUT: assert property (@(posedge clk) disable iff (!srst_n)
        (state == ST_PRE && tmr_exp && !chg_en_n && !sleep_f && !temp_f) |=> (state == ST_FAULT)); // R2

endmodule

// File: tb/chg_seq_bench.sv
module chg_seq_bench;
    localparam int DG   = 3;
    localparam int PRE  = 8;
    localparam int FAST = 30;

    // Expected output vectors {pre_en, fast_en, flt_cur_en, stat1, stat2, pgood_n}
    localparam logic [5:0] E_OFF   = 6'b000000;
    localparam logic [5:0] E_PRE   = 6'b100110;
    localparam logic [5:0] E_FAST  = 6'b010100;
    localparam logic [5:0] E_DONE  = 6'b000010;
    localparam logic [5:0] E_HALT  = 6'b000000;
    localparam logic [5:0] E_FCUR  = 6'b001000;
    localparam logic [5:0] E_SLEEP = 6'b000001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic batt_low = 1'b0;
    logic batt_below_rch = 1'b0;
    logic term_det = 1'b0;
    logic sleep_det = 1'b0;
    logic uvlo = 1'b0;
    logic temp_bad = 1'b0;
    logic chg_en_n = 1'b1;
    logic tmr_en_n = 1'b0;
    logic pre_en, fast_en, flt_cur_en, stat1, stat2, pgood_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    chg_seq #(
        .DG_TICKS   (DG),
        .PRE_TICKS  (PRE),
        .FAST_TICKS (FAST)
    ) u_chg_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .batt_low       (batt_low),
        .batt_below_rch (batt_below_rch),
        .term_det       (term_det),
        .sleep_det      (sleep_det),
        .uvlo           (uvlo),
        .temp_bad       (temp_bad),
        .chg_en_n       (chg_en_n),
        .tmr_en_n       (tmr_en_n),
        .pre_en         (pre_en),
        .fast_en        (fast_en),
        .flt_cur_en     (flt_cur_en),
        .stat1          (stat1),
        .stat2          (stat2),
        .pgood_n        (pgood_n)
    );

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {pre_en, fast_en, flt_cur_en, stat1, stat2, pgood_n};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs %b expected %b", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            settle(2);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(2);
        check("R1 reset standby", E_OFF);

        // Conditioning and its timeout with the battery below top-up level
        chg_en_n = 1'b0; batt_low = 1'b1; batt_below_rch = 1'b1;
        settle(2);
        check("R2 conditioning", E_PRE);
        ticks(PRE - 1);
        check("R2 one tick before timeout", E_PRE);
        ticks(1);
        check("R7 fault with probe current", E_FCUR);

        // Recovery path: rise above top-up level, then fall back
        batt_below_rch = 1'b0; batt_low = 1'b0;
        ticks(DG - 1);
        check("R4 top-up rise not yet filtered", E_FCUR);
        ticks(1);
        check("R7 probe current off above level", E_HALT);
        batt_below_rch = 1'b1;
        ticks(DG);
        check("R7 fault cleared, fast restart", E_FAST);

        // Termination glitch sweep with the fast timer disabled
        tmr_en_n = 1'b1;
        batt_below_rch = 1'b0;
        ticks(DG);
        for (int len = 1; len < DG; len++) begin
            term_det = 1'b1;
            ticks(len);
            term_det = 1'b0;
            settle(2);
            check("R4 short termination pulse ignored", E_FAST);
        end
        term_det = 1'b1;
        ticks(DG);
        term_det = 1'b0;
        settle(2);
        check("R5 done", E_DONE);

        // Top-up restart
        batt_below_rch = 1'b1;
        ticks(DG - 1);
        check("R5 done held before filter", E_DONE);
        ticks(1);
        check("R5 top-up restart", E_FAST);
        tmr_en_n = 1'b0;
        settle(2);
        check("R9 enable change outside fault ignored", E_FAST);

        // Pause mid-count: the count must survive
        ticks(5);
        temp_bad = 1'b1;
        ticks(DG - 1);
        check("R4 temperature not yet filtered", E_FAST);
        ticks(1);
        check("R6 paused", E_HALT);
        ticks(50);
        check("R6 pause held", E_HALT);
        temp_bad = 1'b0;
        settle(2);
        check("R6 resumed fast", E_FAST);
        ticks(FAST - 5 - DG - 1);
        check("R6 count kept, one tick left", E_FAST);
        ticks(1);
        check("R3 fast timeout fault", E_FCUR);

        // Timer-enable change clears the fault
        tmr_en_n = 1'b1;
        settle(3);
        check("R9 toggle clears fault", E_FAST);
        ticks(FAST + 5);
        check("R9 disabled timer does not expire", E_FAST);
        tmr_en_n = 1'b0;
        settle(2);
        check("R9 enable restored", E_FAST);

        // Fast to conditioning fall, then fault entered above top-up level
        batt_below_rch = 1'b0;
        ticks(DG);
        batt_low = 1'b1;
        ticks(DG - 1);
        check("R11 low fall not yet filtered", E_FAST);
        ticks(1);
        check("R11 back to conditioning", E_PRE);
        ticks(PRE - 1);
        check("R2 conditioning before timeout", E_PRE);
        ticks(1);
        check("R7 fault above level, no probe", E_HALT);
        batt_below_rch = 1'b1;
        ticks(DG - 1);
        check("R7 fault held before filter", E_HALT);
        ticks(1);
        check("R7 restart after fall", E_PRE);

        // Charge enable release clears a fault
        ticks(PRE);
        check("R2 second timeout", E_FCUR);
        chg_en_n = 1'b1;
        settle(2);
        check("R8 disabled standby", E_OFF);
        chg_en_n = 1'b0;
        settle(2);
        check("R8 enable restart", E_PRE);
        batt_low = 1'b0;
        settle(2);
        check("R11 unfiltered rise to fast", E_FAST);
        batt_low = 1'b1;
        ticks(DG);
        settle(1);
        check("R11 fall filtered to conditioning", E_PRE);

        // Sleep
        sleep_det = 1'b1;
        ticks(DG - 1);
        check("R4 sleep not yet filtered", E_PRE);
        ticks(1);
        check("R10 sleep", E_SLEEP);
        sleep_det = 1'b0;
        settle(3);
        check("R10 wake restart", E_PRE);

        // Undervoltage
        uvlo = 1'b1;
        settle(2);
        check("R1 undervoltage standby", E_OFF);
        uvlo = 1'b0;
        settle(3);
        check("R1 restart after undervoltage", E_PRE);

        finish_run();
    end
endmodule